// File: doc/BRIEF.md
# LIN Synch-Break Detector and Generator

This block holds the synch-break logic of a serial port that can run a LIN bus. In receive, it counts bit ticks during which the serial input stays dominant (low). When the count reaches eleven and the port is in LIN mode, it sets a sticky break flag. If the break interrupt is enabled, it also raises an interrupt request. In transmit, a one-cycle command pulse starts a break, and the block holds the serial output low for 13 to 16 bit times, as chosen by a two-bit length field.

The block has one 8-bit control byte. It is written through a plain write strobe and can be read at any time. A separate strobe marks a read that belongs to a read-modify-write cycle. Such a read always shows the break flag as 1, so a read-modify-write of any other field can never clear a pending break.

Top module: `lin_brk_top`

## Requirements
- R1: The break flag can only be set while `op_mode` is 2'b11 (LIN mode). In modes 0, 1 and 2, a low input of any length leaves the flag at 0.
- R2: The flag sets on the 11th consecutive `bit_tick` that samples `ser_in` low. Ten low ticks do not set it. A tick that samples `ser_in` high restarts the count. The transmit length field has no effect on this threshold.
- R3: `irq` is 1 exactly when the break flag (control bit 6) and the break interrupt enable (control bit 7) are both 1.
- R4: A write with bit 6 = 0 clears the flag and so drops `irq`. A write with bit 6 = 1 leaves the flag unchanged.
- R5: Control byte layout is: bit 7 enable, bit 6 flag, bits 5:4 transmit length, bits 3:0 read as 0. With `rd_rmw` = 1, bit 6 of `rd_data` reads 1. Writing that byte back does not clear a set flag. With `rd_rmw` = 0, bit 6 shows the true flag.
- R6: In modes 1 and 2, the interrupt enable is held at 0 from the next cycle on, and writes to it have no effect.
- R7: A commanded break drives `ser_out` low for 13, 14, 15 or 16 bit ticks for length codes 00, 01, 10 and 11. `ser_out` then returns high.
- R8: `tx_busy` rises in the cycle after an accepted `tx_start` pulse. It stays high until the last break tick. A `tx_start` pulse while busy is ignored.
- R9: If a flag-clearing write lands in the same cycle as a new detection, the flag ends up set.
- R10: The flag sets only once per low period. After it is cleared, it does not set again until the input has been sampled high and then low for 11 more ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_mode | input | 2 | Operating mode; 2'b11 is LIN mode |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write data |
| rd_rmw | input | 1 | Current read belongs to a read-modify-write cycle |
| rd_data | output | 8 | Control byte read data |
| bit_tick | input | 1 | One-cycle pulse per serial bit time |
| ser_in | input | 1 | Serial input line |
| tx_start | input | 1 | One-cycle pulse that starts a break |
| ser_out | output | 1 | Serial output line (break low, idle high) |
| tx_busy | output | 1 | Break transmission in progress |
| irq | output | 1 | Break interrupt request |

## Verification
The checker assumes that `bit_tick` is a single-cycle pulse and that `tx_start` is a single-cycle command. It also assumes that `op_mode` changes only between bus operations, not while a write is pending. The stimulus gives each tick exactly one cycle, with idle cycles after it. It changes `ser_in` only in cycles that carry a tick, and it changes the mode only between whole test steps. The one deliberate overlap is a clearing write placed on the same cycle as the eleventh low tick, which is how the detection-priority rule is exercised.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;

    typedef enum logic [1:0] {
        MODE_PLAIN = 2'b00,
        MODE_MULTI = 2'b01,
        MODE_SYNC  = 2'b10,
        MODE_LIN   = 2'b11
    } op_mode_e;

    localparam int RX_BRK_BITS  = 11;
    localparam int TX_BASE_BITS = 13;
    localparam int TX_CNT_W     = 5;

    localparam int IE_BIT   = 7;
    localparam int FLAG_BIT = 6;
    localparam int LEN_HI   = 5;
    localparam int LEN_LO   = 4;

    typedef struct packed {
        logic       ie;
        logic       flag;
        logic [1:0] len;
    } ctrl_t;

    function automatic logic [TX_CNT_W-1:0] len_to_bits(input logic [1:0] code);
        return TX_CNT_W'(TX_BASE_BITS) + {{(TX_CNT_W-2){1'b0}}, code};
    endfunction

    function automatic logic [7:0] pack_ctrl(input ctrl_t c, input logic force_flag);
        logic [7:0] b;
        b = 8'h00;
        b[IE_BIT]        = c.ie;
        b[FLAG_BIT]      = c.flag | force_flag;
        b[LEN_HI:LEN_LO] = c.len;
        return b;
    endfunction

endpackage

// File: rtl/lin_brk_regs.sv
module lin_brk_regs
    import lin_brk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  op_mode_e    op_mode,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic        rd_rmw,
    input  logic        det_pulse,
    output ctrl_t       ctrl_q,
    output logic [7:0]  rd_data
);

    logic ie_locked;
    assign ie_locked = (op_mode == MODE_MULTI) || (op_mode == MODE_SYNC);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (det_pulse)
                ctrl_q.flag <= 1'b1;
            else if (wr_en && !wr_data[FLAG_BIT])
                ctrl_q.flag <= 1'b0;

            if (ie_locked)
                ctrl_q.ie <= 1'b0;
            else if (wr_en)
                ctrl_q.ie <= wr_data[IE_BIT];

            if (wr_en)
                ctrl_q.len <= wr_data[LEN_HI:LEN_LO];
        end
    end

    assign rd_data = pack_ctrl(ctrl_q, rd_rmw);

endmodule

// File: rtl/lin_brk_rxdet.sv
module lin_brk_rxdet
    import lin_brk_pkg::*;
#(
    parameter int BRK_BITS = RX_BRK_BITS
) (
    input  logic     clk,
    input  logic     rst,
    input  op_mode_e op_mode,
    input  logic     bit_tick,
    input  logic     ser_in,
    output logic     det_pulse
);

    localparam int CW = $clog2(BRK_BITS + 1);
    localparam logic [CW-1:0] LAST  = CW'(BRK_BITS - 1);
    localparam logic [CW-1:0] SATUR = CW'(BRK_BITS);

    logic [CW-1:0] low_cnt;
    logic          lin_on;

    assign lin_on = (op_mode == MODE_LIN);

    always_ff @(posedge clk) begin
        if (rst || !lin_on) begin
            low_cnt <= '0;
        end else if (bit_tick) begin
            if (ser_in)
                low_cnt <= '0;
            else if (low_cnt != SATUR)
                low_cnt <= low_cnt + 1'b1;
        end
    end

    assign det_pulse = lin_on && bit_tick && !ser_in && (low_cnt == LAST);

endmodule

// File: rtl/lin_brk_txgen.sv
module lin_brk_txgen
    import lin_brk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_tick,
    input  logic       tx_start,
    input  logic [1:0] len_code,
    output logic       tx_busy,
    output logic       ser_out
);

    logic [TX_CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (tx_start && remain == '0)
            remain <= len_to_bits(len_code);
        else if (bit_tick && remain != '0)
            remain <= remain - 1'b1;
    end

    assign tx_busy = (remain != '0);
    assign ser_out = !tx_busy;

endmodule

// File: rtl/lin_brk_top.sv
module lin_brk_top
    import lin_brk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] op_mode,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_rmw,
    output logic [7:0] rd_data,
    input  logic       bit_tick,
    input  logic       ser_in,
    input  logic       tx_start,
    output logic       ser_out,
    output logic       tx_busy,
    output logic       irq
);

    op_mode_e mode;
    ctrl_t    ctrl_q;
    logic     det_pulse;
    logic     flag_q;
    logic     ie_q;

    assign mode   = op_mode_e'(op_mode);
    assign flag_q = ctrl_q.flag;
    assign ie_q   = ctrl_q.ie;

    lin_brk_rxdet #(.BRK_BITS(RX_BRK_BITS)) rx_i (
        .clk(clk), .rst(rst), .op_mode(mode),
        .bit_tick(bit_tick), .ser_in(ser_in), .det_pulse(det_pulse)
    );

    lin_brk_regs regs_i (
        .clk(clk), .rst(rst), .op_mode(mode),
        .wr_en(wr_en), .wr_data(wr_data), .rd_rmw(rd_rmw),
        .det_pulse(det_pulse), .ctrl_q(ctrl_q), .rd_data(rd_data)
    );

    lin_brk_txgen tx_i (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_start(tx_start),
        .len_code(ctrl_q.len), .tx_busy(tx_busy), .ser_out(ser_out)
    );

    assign irq = flag_q & ie_q;

endmodule

// File: rtl/lin_brk_chk.sv
module lin_brk_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] op_mode,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       rd_rmw,
    input logic [7:0] rd_data,
    input logic       bit_tick,
    input logic       tx_start,
    input logic       tx_busy,
    input logic       irq,
    input logic       det_pulse,
    input logic       flag_q,
    input logic       ie_q
);

    AST_SET_ONLY_LIN: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(op_mode) == 2'b11); // R1

    AST_IRQ_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag_q && ie_q)); // R3

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[6] && !det_pulse) |=> !flag_q); // R4

    AST_RMW_FLAG_ONE: assert property (@(posedge clk) disable iff (rst)
        rd_rmw |-> rd_data[6]); // R5

    AST_IE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (op_mode == 2'b01 || op_mode == 2'b10) |=> !ie_q); // R6

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (tx_start && !tx_busy) |=> tx_busy); // R8

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (tx_busy && !bit_tick) |=> tx_busy); // R8

    AST_DET_WINS: assert property (@(posedge clk) disable iff (rst)
        det_pulse |=> flag_q); // R9

endmodule

bind lin_brk_top lin_brk_chk chk_i (
    .clk(clk), .rst(rst), .op_mode(op_mode), .wr_en(wr_en), .wr_data(wr_data),
    .rd_rmw(rd_rmw), .rd_data(rd_data), .bit_tick(bit_tick), .tx_start(tx_start),
    .tx_busy(tx_busy), .irq(irq), .det_pulse(det_pulse), .flag_q(flag_q), .ie_q(ie_q)
);

// File: tb/lin_brk_top_tb.sv
module lin_brk_top_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0] low_ticks;
        logic [1:0] len;
        logic       exp_flag;
        logic [7:0] exp_bits;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'd5,  2'b00, 1'b0, 8'd13},
        '{8'd10, 2'b01, 1'b0, 8'd14},
        '{8'd11, 2'b10, 1'b1, 8'd15},
        '{8'd12, 2'b11, 1'b1, 8'd16},
        '{8'd20, 2'b00, 1'b1, 8'd13},
        '{8'd0,  2'b11, 1'b0, 8'd16}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] op_mode = 2'b11;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_rmw = 1'b0;
    logic [7:0] rd_data;
    logic       bit_tick = 1'b0;
    logic       ser_in = 1'b1;
    logic       tx_start = 1'b0;
    logic       ser_out;
    logic       tx_busy;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lin_brk_top dut_i (
        .clk(clk), .rst(rst), .op_mode(op_mode), .wr_en(wr_en), .wr_data(wr_data),
        .rd_rmw(rd_rmw), .rd_data(rd_data), .bit_tick(bit_tick), .ser_in(ser_in),
        .tx_start(tx_start), .ser_out(ser_out), .tx_busy(tx_busy), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n, input logic lvl);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ser_in = lvl;
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
    endtask

    task automatic count_break(output int n);
        n = 0;
        while (tx_busy && n < 40) begin
            ticks(1, 1'b1);
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        logic [7:0] snap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state (R5 layout, R7 idle high, R3 no request)
        check("R5 reset rd_data", rd_data, 0);
        check("R3 reset irq", irq, 0);
        check("R7 reset ser_out", ser_out, 1);
        check("R8 reset busy", tx_busy, 0);

        // Table walk: R2 receive threshold, R3 irq, R7 transmit lengths
        for (int v = 0; v < 6; v++) begin
            op_mode = 2'b11;
            write({1'b1, 1'b0, VECS[v].len, 4'h0});
            ticks(1, 1'b1);
            ticks(int'(VECS[v].low_ticks), 1'b0);
            ticks(1, 1'b1);
            check("R2 flag after low run", rd_data[6], VECS[v].exp_flag);
            check("R3 irq follows flag", irq, VECS[v].exp_flag);
            pulse_start();
            check("R8 busy after start", tx_busy, 1);
            check("R7 out low in break", ser_out, 0);
            count_break(n);
            check("R7 break length", n, int'(VECS[v].exp_bits));
            check("R7 out high after", ser_out, 1);
        end

        // R1: no detection outside LIN mode
        op_mode = 2'b00;
        write(8'h00);
        ticks(1, 1'b1);
        ticks(14, 1'b0);
        ticks(1, 1'b1);
        check("R1 mode0 no flag", rd_data[6], 0);
        op_mode = 2'b10;
        ticks(14, 1'b0);
        ticks(1, 1'b1);
        check("R1 mode2 no flag", rd_data[6], 0);

        // R2: high sample restarts count
        op_mode = 2'b11;
        ticks(8, 1'b0);
        ticks(1, 1'b1);
        ticks(8, 1'b0);
        ticks(1, 1'b1);
        check("R2 restart on high", rd_data[6], 0);

        // R4 and R5: set flag, then exercise writes and RMW reads
        write(8'h80);
        ticks(11, 1'b0);
        ticks(1, 1'b1);
        check("R4 flag set", rd_data[6], 1);
        write(8'hC0);
        check("R4 write 1 keeps flag", rd_data[6], 1);
        rd_rmw = 1'b1;
        @(negedge clk);
        snap = rd_data;
        rd_rmw = 1'b0;
        check("R5 rmw read bit6", snap[6], 1);
        write(snap);
        check("R5 rmw writeback keeps flag", rd_data[6], 1);
        check("R3 irq with ie and flag", irq, 1);
        write(8'h80);
        check("R4 clear flag", rd_data[6], 0);
        check("R4 clear drops irq", irq, 0);
        rd_rmw = 1'b1;
        @(negedge clk);
        check("R5 rmw reads 1 when clear", rd_data[6], 1);
        rd_rmw = 1'b0;
        @(negedge clk);
        check("R5 normal read true flag", rd_data[6], 0);

        // R3: flag without enable gives no request
        write(8'h00);
        ticks(11, 1'b0);
        ticks(1, 1'b1);
        check("R3 flag set ie off", rd_data[6], 1);
        check("R3 irq low without ie", irq, 0);
        write(8'h00);

        // R6: enable locked in modes 1 and 2
        write(8'h80);
        check("R6 ie writable in LIN", rd_data[7], 1);
        op_mode = 2'b01;
        @(negedge clk);
        check("R6 ie forced in mode1", rd_data[7], 0);
        write(8'h80);
        check("R6 write ignored mode1", rd_data[7], 0);
        op_mode = 2'b10;
        write(8'h80);
        check("R6 write ignored mode2", rd_data[7], 0);
        op_mode = 2'b11;

        // R9: clearing write on the detecting tick
        write(8'h00);
        ticks(1, 1'b1);
        ticks(10, 1'b0);
        @(negedge clk);
        ser_in = 1'b0;
        bit_tick = 1'b1;
        wr_en = 1'b1;
        wr_data = 8'h00;
        @(negedge clk);
        bit_tick = 1'b0;
        wr_en = 1'b0;
        check("R9 detection wins", rd_data[6], 1);

        // R10: one set per low period
        write(8'h00);
        ticks(6, 1'b0);
        check("R10 no second set", rd_data[6], 0);
        ticks(1, 1'b1);
        ticks(11, 1'b0);
        check("R10 new period sets", rd_data[6], 1);
        ticks(1, 1'b1);
        write(8'h00);

        // R8: start while busy ignored
        write(8'h00);
        pulse_start();
        ticks(5, 1'b1);
        pulse_start();
        count_break(n);
        check("R8 restart ignored", n + 5, 13);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule